// File: doc/BRIEF.md
# Rename Stage Flow-Control State Machine

This block is the control engine of one thread in an out-of-order rename stage. Every cycle it chooses the stage's mode: idle, running, blocked, draining held work, recovering from a squash, or parked behind a serializing instruction. It accepts at most one instruction per cycle, either from decode or from its own skid buffer. It passes that instruction on or holds it back, and it sends single-cycle block and release pulses back to decode.

Register renaming and the resource counters are not part of this block. Free entries downstream arrive as one "resources available" flag. Back-end drain status arrives as a "reorder buffer empty" flag and a "nothing in flight" flag.

The skid buffer is sized from the decode width, the rename width and the return delay of the execute stage. It catches instructions that decode sent before it saw a block pulse. An instruction that must wait for the back end to drain is held apart from that buffer. When the wait ends, it is put back at the head of the buffer so that it leaves ahead of everything queued behind it.

Top module: `rename_flow_ctl`

## Requirements
- R1: After reset, fsm_state is 0 (idle), out_valid, dec_block, dec_unblock and skid_overflow are 0, and skid_level is 0.
- R2: A squash request has top priority. The state becomes squashing (4) and the skid buffer and any held serializing instruction are discarded. dec_unblock pulses only if the state was blocked (2), unblocking (3) or serialize-wait (5).
- R3: While be_squashing is high (and no squash request), the state is squashing (4) and inputs are dropped. From squashing with neither flag set, the stage runs (1) and handles that cycle's input.
- R4: A stall from the execute or commit stage moves the incoming instruction into the skid buffer and sets state blocked (2). dec_block pulses only if the state was neither blocked nor unblocking. A stage in serialize-wait (5) stays there.
- R5: From blocked with no stall the stage unblocks (3). It issues skid entries oldest first, one per cycle, while new arrivals join the tail. On the cycle the buffer becomes empty it returns to running (1) with a dec_unblock pulse.
- R6: With res_ok low and an instruction to process, the stage blocks under the same pulse rules as R4, and nothing issues.
- R7: An instruction with the serialize-before attribute is not issued. The state becomes serialize-wait (5) with a dec_block pulse. It stays there, issuing nothing and buffering arrivals, until rob_empty and inflight_zero are both high.
- R8: When serialize-wait ends, the held instruction is placed at the head of the skid buffer and the state becomes unblocking (3). The held instruction issues before all other buffered entries, without stalling a second time.
- R9: An issued instruction with the serialize-after attribute makes the next processed instruction act as serialize-before, unless the back end is drained (rob_empty and inflight_zero) when that instruction is processed. The mark is used once.
- R10: The skid buffer holds 2*(EXE_DLY*DEC_W)+REN_W entries (5 by default). A push into a full buffer is dropped and sets skid_overflow, which stays high until reset.
- R11: An issued instruction appears on out_valid/out_id one clock edge after it is presented (from decode or from the skid head). All outputs are registered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| squash_req | input | 1 | Squash request from the back end |
| be_squashing | input | 1 | Back end still squashing |
| exe_stall | input | 1 | Stall from the execute stage |
| cmt_stall | input | 1 | Stall from the commit stage |
| res_ok | input | 1 | Downstream resources available |
| rob_empty | input | 1 | Reorder buffer empty |
| inflight_zero | input | 1 | No instructions in flight toward the reorder buffer |
| in_valid | input | 1 | Instruction from decode valid |
| in_id | input | ID_W | Instruction tag |
| in_ser_before | input | 1 | Instruction must wait for an empty back end |
| in_ser_after | input | 1 | Next instruction must wait for an empty back end |
| out_valid | output | 1 | Instruction issued |
| out_id | output | ID_W | Tag of the issued instruction (0 when not valid) |
| dec_block | output | 1 | Block pulse to decode |
| dec_unblock | output | 1 | Release pulse to decode |
| fsm_state | output | 3 | 0 idle, 1 running, 2 blocked, 3 unblocking, 4 squashing, 5 serialize-wait |
| skid_level | output | CW | Entries in the skid buffer |
| skid_overflow | output | 1 | Sticky skid overflow flag |

## Verification
Every result of this block is registered, so the effect of inputs presented in a cycle is due exactly one clock edge later. This holds for the next state, the issued tag, both decode pulses, the skid level and the overflow flag. The bench drives inputs on the falling edge and compares all outputs shortly after the following rising edge, one vector per cycle. The reordering cases therefore show up as the tag sequence over several consecutive cycles: a serialize-wait exit places its instruction ahead of older buffered ones, and an unblock issues buffered entries before newer arrivals.

// File: rtl/rnf_pkg.sv
package rnf_pkg;

    typedef enum logic [2:0] {
        ST_IDLE = 3'd0,
        ST_RUN  = 3'd1,
        ST_BLK  = 3'd2,
        ST_UNB  = 3'd3,
        ST_SQ   = 3'd4,
        ST_SER  = 3'd5
    } rn_state_e;

    // Flag bits carried under the tag in every buffered entry
    localparam int FLAG_W   = 3;
    localparam int F_SB     = 2;   // wait for empty back end before issue
    localparam int F_SA     = 1;   // next instruction must wait
    localparam int F_DONE   = 0;   // serialization already handled

    function automatic int skid_cap(input int exe_dly, input int dec_w, input int ren_w);
        return 2 * (exe_dly * dec_w) + ren_w;
    endfunction

endpackage

// File: rtl/rnf_skid.sv
module rnf_skid #(
    parameter int DEPTH = 5,
    parameter int DW    = 11,
    localparam int PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          flush,
    input  logic          pop,
    input  logic          push_back,
    input  logic [DW-1:0] push_back_data,
    input  logic          push_front,
    input  logic [DW-1:0] push_front_data,
    output logic [DW-1:0] head_data,
    output logic [CW-1:0] level,
    output logic          ovf
);

    typedef struct packed {
        logic [PW-1:0] head;
        logic [PW-1:0] tail;
        logic [CW-1:0] cnt;
    } ptr_t;

    ptr_t          ptr_d, ptr_q;
    logic [DW-1:0] mem_d [DEPTH];
    logic [DW-1:0] mem_q [DEPTH];

    function automatic logic [PW-1:0] wrap_inc(input logic [PW-1:0] p);
        return (int'(p) == DEPTH - 1) ? '0 : p + 1'b1;
    endfunction

    function automatic logic [PW-1:0] wrap_dec(input logic [PW-1:0] p);
        return (p == '0) ? PW'(DEPTH - 1) : p - 1'b1;
    endfunction

    logic do_pop, do_pf, do_pb;
    int   room;

    always_comb begin
        ptr_d = ptr_q;
        mem_d = mem_q;
        do_pop = pop && (ptr_q.cnt != '0);
        room   = DEPTH - int'(ptr_q.cnt) + (do_pop ? 1 : 0);
        do_pf  = push_front && (room >= 1);
        do_pb  = push_back && (room >= 1 + (do_pf ? 1 : 0));
        ovf    = (push_front && !do_pf) || (push_back && !do_pb);

        if (do_pop) begin
            ptr_d.head = wrap_inc(ptr_q.head);
        end
        if (do_pf) begin
            ptr_d.head = wrap_dec(ptr_d.head);
            mem_d[ptr_d.head] = push_front_data;
        end
        if (do_pb) begin
            mem_d[ptr_q.tail] = push_back_data;
            ptr_d.tail = wrap_inc(ptr_q.tail);
        end
        ptr_d.cnt = CW'(int'(ptr_q.cnt) + (do_pf ? 1 : 0) + (do_pb ? 1 : 0) - (do_pop ? 1 : 0));

        if (flush) begin
            ptr_d = '0;
            ovf   = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ptr_q <= '0;
        end else begin
            ptr_q <= ptr_d;
        end
        mem_q <= mem_d;
    end

    assign head_data = mem_q[ptr_q.head];
    assign level     = ptr_q.cnt;

    // R10: occupancy never exceeds the capacity
    p_level_cap_r10: assert property (@(posedge clk) disable iff (!rst_n)
        int'(ptr_q.cnt) <= DEPTH);

    // R2: a flush leaves the buffer empty
    p_flush_clears_r2: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (ptr_q.cnt == '0));

endmodule

// File: rtl/rnf_ctl.sv
module rnf_ctl
    import rnf_pkg::*;
#(
    parameter int ID_W = 8,
    parameter int CW   = 3,
    localparam int EW  = ID_W + FLAG_W
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            squash_req,
    input  logic            be_squashing,
    input  logic            exe_stall,
    input  logic            cmt_stall,
    input  logic            res_ok,
    input  logic            rob_empty,
    input  logic            inflight_zero,
    input  logic            in_valid,
    input  logic [ID_W-1:0] in_id,
    input  logic            in_ser_before,
    input  logic            in_ser_after,
    input  logic [EW-1:0]   skid_head,
    input  logic [CW-1:0]   skid_level,
    input  logic            skid_ovf,
    output logic            skid_flush,
    output logic            skid_pop,
    output logic            skid_pb,
    output logic [EW-1:0]   skid_pb_data,
    output logic            skid_pf,
    output logic [EW-1:0]   skid_pf_data,
    output rn_state_e       state,
    output logic            out_valid,
    output logic [ID_W-1:0] out_id,
    output logic            dec_block,
    output logic            dec_unblock,
    output logic            err
);

    typedef struct packed {
        rn_state_e       st;
        logic [EW-1:0]   hold;
        logic            pend;
        logic            ov;
        logic [ID_W-1:0] oid;
        logic            blk;
        logic            unblk;
        logic            err;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    logic          drained;
    logic          stall;
    logic          run_step;
    rn_state_e     eff;
    logic          src_valid;
    logic [EW-1:0] src;
    logic [EW-1:0] in_entry;
    logic          want_sb;
    int            left;

    assign drained  = rob_empty && inflight_zero;
    assign stall    = exe_stall || cmt_stall;
    assign in_entry = {in_id, in_ser_before, in_ser_after, 1'b0};

    always_comb begin
        ctl_d       = ctl_q;
        ctl_d.ov    = 1'b0;
        ctl_d.oid   = '0;
        ctl_d.blk   = 1'b0;
        ctl_d.unblk = 1'b0;
        skid_flush   = 1'b0;
        skid_pop     = 1'b0;
        skid_pb      = 1'b0;
        skid_pb_data = in_entry;
        skid_pf      = 1'b0;
        skid_pf_data = ctl_q.hold | EW'(1 << F_DONE);
        run_step  = 1'b0;
        eff       = ctl_q.st;
        src_valid = 1'b0;
        src       = in_entry;
        want_sb   = 1'b0;
        left      = 0;

        if (squash_req) begin
            if (ctl_q.st inside {ST_BLK, ST_UNB, ST_SER}) ctl_d.unblk = 1'b1;
            ctl_d.st   = ST_SQ;
            ctl_d.pend = 1'b0;
            ctl_d.hold = '0;
            skid_flush = 1'b1;
        end else if (be_squashing) begin
            ctl_d.st   = ST_SQ;
            ctl_d.pend = 1'b0;
            skid_flush = 1'b1;
        end else if (stall) begin
            skid_pb = in_valid;
            if (!(ctl_q.st inside {ST_BLK, ST_UNB})) ctl_d.blk = 1'b1;
            if (ctl_q.st != ST_SER) ctl_d.st = ST_BLK;
        end else begin
            unique case (ctl_q.st)
                ST_BLK: begin eff = ST_UNB; run_step = 1'b1; end
                ST_SQ:  begin eff = ST_RUN; run_step = 1'b1; end
                ST_SER: begin
                    skid_pb = in_valid;
                    if (drained) begin
                        skid_pf  = 1'b1;
                        ctl_d.st = ST_UNB;
                    end
                end
                default: run_step = 1'b1;
            endcase
        end

        if (run_step) begin
            ctl_d.st = eff;
            if (eff == ST_UNB) begin
                src_valid = (skid_level != '0);
                src       = skid_head;
                skid_pb   = in_valid;
            end else begin
                src_valid = in_valid;
                src       = in_entry;
            end

            if (src_valid) begin
                if (!res_ok) begin
                    if (eff != ST_UNB) begin
                        skid_pb   = in_valid;
                        ctl_d.blk = 1'b1;
                    end
                    ctl_d.st = ST_BLK;
                end else begin
                    want_sb    = src[F_SB] || (ctl_q.pend && !drained);
                    ctl_d.pend = 1'b0;
                    skid_pop   = (eff == ST_UNB);
                    if (want_sb && !src[F_DONE]) begin
                        ctl_d.st   = ST_SER;
                        ctl_d.hold = src;
                        ctl_d.blk  = 1'b1;
                    end else begin
                        ctl_d.ov  = 1'b1;
                        ctl_d.oid = src[EW-1:FLAG_W];
                        if (src[F_SA] && !src[F_DONE]) ctl_d.pend = 1'b1;
                        if (eff == ST_IDLE) ctl_d.st = ST_RUN;
                    end
                end
            end

            if (ctl_d.st == ST_UNB) begin
                left = int'(skid_level) - (skid_pop ? 1 : 0) + (skid_pb ? 1 : 0);
                if (left == 0) begin
                    ctl_d.st    = ST_RUN;
                    ctl_d.unblk = 1'b1;
                end
            end
        end

        if (skid_ovf) ctl_d.err = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl_q    <= '0;
            ctl_q.st <= ST_IDLE;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign state       = ctl_q.st;
    assign out_valid   = ctl_q.ov;
    assign out_id      = ctl_q.oid;
    assign dec_block   = ctl_q.blk;
    assign dec_unblock = ctl_q.unblk;
    assign err         = ctl_q.err;

    // R2: squash always lands in the squashing state
    p_squash_enters_r2: assert property (@(posedge clk) disable iff (!rst_n)
        squash_req |=> (ctl_q.st == ST_SQ));

    // R2: squash out of a held state releases decode
    p_squash_release_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (squash_req && (ctl_q.st inside {ST_BLK, ST_UNB, ST_SER})) |=> ctl_q.unblk);

    // R4: no repeated block pulse while decode already sees the stage held
    p_block_silent_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (stall && !squash_req && !be_squashing && (ctl_q.st inside {ST_BLK, ST_UNB}))
        |=> !ctl_q.blk);

    // R4: a stall never leaves serialize-wait for blocked
    p_ser_kept_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (stall && !squash_req && !be_squashing && (ctl_q.st == ST_SER))
        |=> (ctl_q.st == ST_SER));

    // R7: nothing issues while waiting on a serializing instruction
    p_ser_no_issue_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_q.st == ST_SER) |-> !ctl_q.ov);

    // R5: block and release pulses never coincide
    p_pulse_excl_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !(ctl_q.blk && ctl_q.unblk));

endmodule

// File: rtl/rename_flow_ctl.sv
module rename_flow_ctl
    import rnf_pkg::*;
#(
    parameter int ID_W    = 8,
    parameter int EXE_DLY = 2,
    parameter int DEC_W   = 1,
    parameter int REN_W   = 1,
    localparam int DEPTH  = skid_cap(EXE_DLY, DEC_W, REN_W),
    localparam int CW     = $clog2(DEPTH + 1),
    localparam int EW     = ID_W + FLAG_W
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            squash_req,
    input  logic            be_squashing,
    input  logic            exe_stall,
    input  logic            cmt_stall,
    input  logic            res_ok,
    input  logic            rob_empty,
    input  logic            inflight_zero,
    input  logic            in_valid,
    input  logic [ID_W-1:0] in_id,
    input  logic            in_ser_before,
    input  logic            in_ser_after,
    output logic            out_valid,
    output logic [ID_W-1:0] out_id,
    output logic            dec_block,
    output logic            dec_unblock,
    output logic [2:0]      fsm_state,
    output logic [CW-1:0]   skid_level,
    output logic            skid_overflow
);

    logic          sk_flush, sk_pop, sk_pb, sk_pf, sk_ovf;
    logic [EW-1:0] sk_pb_data, sk_pf_data, sk_head;
    rn_state_e     st;

    rnf_skid #(.DEPTH(DEPTH), .DW(EW)) u_skid (
        .clk             (clk),
        .rst_n           (rst_n),
        .flush           (sk_flush),
        .pop             (sk_pop),
        .push_back       (sk_pb),
        .push_back_data  (sk_pb_data),
        .push_front      (sk_pf),
        .push_front_data (sk_pf_data),
        .head_data       (sk_head),
        .level           (skid_level),
        .ovf             (sk_ovf)
    );

    rnf_ctl #(.ID_W(ID_W), .CW(CW)) u_ctl (
        .clk           (clk),
        .rst_n         (rst_n),
        .squash_req    (squash_req),
        .be_squashing  (be_squashing),
        .exe_stall     (exe_stall),
        .cmt_stall     (cmt_stall),
        .res_ok        (res_ok),
        .rob_empty     (rob_empty),
        .inflight_zero (inflight_zero),
        .in_valid      (in_valid),
        .in_id         (in_id),
        .in_ser_before (in_ser_before),
        .in_ser_after  (in_ser_after),
        .skid_head     (sk_head),
        .skid_level    (skid_level),
        .skid_ovf      (sk_ovf),
        .skid_flush    (sk_flush),
        .skid_pop      (sk_pop),
        .skid_pb       (sk_pb),
        .skid_pb_data  (sk_pb_data),
        .skid_pf       (sk_pf),
        .skid_pf_data  (sk_pf_data),
        .state         (st),
        .out_valid     (out_valid),
        .out_id        (out_id),
        .dec_block     (dec_block),
        .dec_unblock   (dec_unblock),
        .err           (skid_overflow)
    );

    assign fsm_state = st;

endmodule

// File: tb/tb_rename_flow_ctl.sv
module tb_rename_flow_ctl;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       squash_req, be_squashing, exe_stall, cmt_stall, res_ok;
    logic       rob_empty, inflight_zero, in_valid, in_ser_before, in_ser_after;
    logic [7:0] in_id;
    logic       out_valid, dec_block, dec_unblock, skid_overflow;
    logic [7:0] out_id;
    logic [2:0] fsm_state;
    logic [2:0] skid_level;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    rename_flow_ctl dut (
        .clk(clk), .rst_n(rst_n), .squash_req(squash_req), .be_squashing(be_squashing),
        .exe_stall(exe_stall), .cmt_stall(cmt_stall), .res_ok(res_ok),
        .rob_empty(rob_empty), .inflight_zero(inflight_zero), .in_valid(in_valid),
        .in_id(in_id), .in_ser_before(in_ser_before), .in_ser_after(in_ser_after),
        .out_valid(out_valid), .out_id(out_id), .dec_block(dec_block),
        .dec_unblock(dec_unblock), .fsm_state(fsm_state), .skid_level(skid_level),
        .skid_overflow(skid_overflow)
    );

    typedef struct packed {
        logic [3:0] req;
        logic sq; logic be; logic st; logic ok; logic re; logic iz; logic v;
        logic [7:0] id; logic sb; logic sa;
        logic [2:0] est; logic eov; logic [7:0] eid; logic eblk; logic eunb;
        logic [2:0] elvl;
    } vec_t;

    localparam int NV = 33;
    // fields: req, sq,be,st,ok,re,iz,v,id,sb,sa | state,ov,id,blk,unblk,level
    localparam vec_t VECS [NV] = '{
        '{11, 0,0,0,1,1,1,1, 1,0,0, 1,1, 1,0,0,0},  // R11 issue from idle
        '{11, 0,0,0,1,1,1,1, 2,0,0, 1,1, 2,0,0,0},  // R11
        '{ 4, 0,0,1,1,1,1,1, 3,0,0, 2,0, 0,1,0,1},  // R4 stall, pulse
        '{ 4, 0,0,1,1,1,1,1, 4,0,0, 2,0, 0,0,0,2},  // R4 no repeat pulse
        '{ 5, 0,0,0,1,1,1,1, 5,0,0, 3,1, 3,0,0,2},  // R5 drain oldest
        '{ 5, 0,0,0,1,1,1,0, 0,0,0, 3,1, 4,0,0,1},  // R5
        '{ 5, 0,0,0,1,1,1,0, 0,0,0, 1,1, 5,0,1,0},  // R5 empty -> running
        '{ 6, 0,0,0,0,1,1,1, 6,0,0, 2,0, 0,1,0,1},  // R6 no resources
        '{ 5, 0,0,0,1,1,1,0, 0,0,0, 1,1, 6,0,1,0},  // R5
        '{ 7, 0,0,0,1,0,1,1, 7,1,0, 5,0, 0,1,0,0},  // R7 enter wait
        '{ 7, 0,0,0,1,0,1,1, 8,0,0, 5,0, 0,0,0,1},  // R7 arrivals buffered
        '{ 7, 0,0,0,1,1,0,0, 0,0,0, 5,0, 0,0,0,1},  // R7 in flight keeps wait
        '{ 8, 0,0,0,1,1,1,1, 9,0,0, 3,0, 0,0,0,3},  // R8 held to head
        '{ 8, 0,0,0,1,1,1,0, 0,0,0, 3,1, 7,0,0,2},  // R8 held first
        '{ 8, 0,0,0,1,1,1,0, 0,0,0, 3,1, 8,0,0,1},  // R8
        '{ 8, 0,0,0,1,1,1,0, 0,0,0, 1,1, 9,0,1,0},  // R8
        '{ 9, 0,0,0,1,1,1,1,10,0,1, 1,1,10,0,0,0},  // R9 serialize-after
        '{ 9, 0,0,0,1,0,1,1,11,0,0, 5,0, 0,1,0,0},  // R9 next waits
        '{ 8, 0,0,0,1,1,1,0, 0,0,0, 3,0, 0,0,0,1},  // R8 empty buffer exit
        '{ 8, 0,0,0,1,1,1,0, 0,0,0, 1,1,11,0,1,0},  // R8
        '{ 9, 0,0,0,1,1,1,1,12,0,1, 1,1,12,0,0,0},  // R9
        '{ 9, 0,0,0,1,1,1,1,13,0,0, 1,1,13,0,0,0},  // R9 drained: mark dropped
        '{ 9, 0,0,0,1,0,1,1,14,0,0, 1,1,14,0,0,0},  // R9 mark used once
        '{ 4, 0,0,1,1,1,1,1,15,0,0, 2,0, 0,1,0,1},  // R4
        '{ 2, 1,0,0,1,1,1,0, 0,0,0, 4,0, 0,0,1,0},  // R2 squash from blocked
        '{ 3, 0,1,0,1,1,1,1,16,0,0, 4,0, 0,0,0,0},  // R3 input dropped
        '{ 3, 0,0,0,1,1,1,1,17,0,0, 1,1,17,0,0,0},  // R3 resume
        '{ 7, 0,0,0,1,0,1,1,18,1,0, 5,0, 0,1,0,0},  // R7
        '{ 4, 0,0,1,1,0,1,0, 0,0,0, 5,0, 0,1,0,0},  // R4 stays in wait
        '{ 2, 1,0,0,1,0,1,0, 0,0,0, 4,0, 0,0,1,0},  // R2 squash from wait
        '{ 3, 0,0,0,1,1,1,0, 0,0,0, 1,0, 0,0,0,0},  // R3 held dropped
        '{ 2, 1,0,0,1,1,1,0, 0,0,0, 4,0, 0,0,0,0},  // R2 no pulse from running
        '{ 3, 0,0,0,1,1,1,0, 0,0,0, 1,0, 0,0,0,0}   // R3
    };

    task automatic drive(input vec_t v);
        squash_req = v.sq; be_squashing = v.be; exe_stall = v.st; cmt_stall = 1'b0;
        res_ok = v.ok; rob_empty = v.re; inflight_zero = v.iz; in_valid = v.v;
        in_id = v.id; in_ser_before = v.sb; in_ser_after = v.sa;
    endtask

    task automatic idle_inputs();
        squash_req = 0; be_squashing = 0; exe_stall = 0; cmt_stall = 0; res_ok = 1;
        rob_empty = 1; inflight_zero = 1; in_valid = 0; in_id = 0;
        in_ser_before = 0; in_ser_after = 0;
    endtask

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %0h expected %0h", tag, act, exp);
        end
    endtask

    initial begin
        #400000;
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        idle_inputs();
        rst_n = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R1 reset state
        chk("R1 state", 16'(fsm_state), 16'd0);
        chk("R1 outputs", 16'({out_valid, dec_block, dec_unblock, skid_overflow}), 16'd0);
        chk("R1 level", 16'(skid_level), 16'd0);

        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            drive(VECS[i]);
            @(posedge clk);
            #1;
            checks++;
            if (fsm_state !== VECS[i].est || out_valid !== VECS[i].eov ||
                (VECS[i].eov && out_id !== VECS[i].eid) ||
                dec_block !== VECS[i].eblk || dec_unblock !== VECS[i].eunb ||
                skid_level !== VECS[i].elvl) begin
                errors++;
                $display("FAIL R%0d vec %0d actual st%0d v%0d id%0d b%0d u%0d l%0d expected st%0d v%0d id%0d b%0d u%0d l%0d",
                    VECS[i].req, i, fsm_state, out_valid, out_id, dec_block, dec_unblock, skid_level,
                    VECS[i].est, VECS[i].eov, VECS[i].eid, VECS[i].eblk, VECS[i].eunb, VECS[i].elvl);
            end
        end

        // R10: fill the skid buffer through a commit stall, then overflow it
        for (int k = 0; k < 5; k++) begin
            @(negedge clk);
            idle_inputs();
            cmt_stall = 1; in_valid = 1; in_id = 8'(40 + k);
            @(posedge clk);
            #1;
        end
        chk("R10 full level", 16'(skid_level), 16'd5);
        chk("R10 no overflow yet", 16'(skid_overflow), 16'd0);
        @(negedge clk);
        in_id = 8'd45;
        @(posedge clk);
        #1;
        chk("R10 overflow flag", 16'(skid_overflow), 16'd1);
        chk("R10 level capped", 16'(skid_level), 16'd5);
        @(negedge clk);
        idle_inputs();
        squash_req = 1;
        @(posedge clk);
        #1;
        chk("R2 flush level", 16'(skid_level), 16'd0);
        chk("R10 sticky", 16'(skid_overflow), 16'd1);

        // R1: reset clears the sticky flag and state
        @(negedge clk);
        idle_inputs();
        rst_n = 0;
        @(posedge clk);
        #1;
        chk("R1 reset clears overflow", 16'({skid_overflow, fsm_state}), 16'd0);
        @(negedge clk);
        rst_n = 1;

        // R11: issue latency is exactly one edge
        @(negedge clk);
        in_valid = 1; in_id = 8'd77;
        #1;
        chk("R11 not before edge", 16'(out_valid), 16'd0);
        @(posedge clk);
        #1;
        chk("R11 after edge", 16'({out_valid, out_id}), 16'h14D);
        @(negedge clk);
        idle_inputs();
        @(posedge clk);
        #1;
        chk("R11 single cycle", 16'(out_valid), 16'd0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule